// File: doc/BRIEF.md
# MAC soft reset sequencer

This block runs the soft reset of an Ethernet MAC. Software starts it by writing a control register with the reset field set. The sequencer then asks the receive and transmit datapaths to stop at their next safe point. The receive side may leave a truncated frame in its FIFO. The transmit side may fall straight to idle and leave its frame unterminated.

Once both paths report idle, or once a bounded wait has run out, the sequencer does the following in order:

- It fires a one-cycle strobe that clears the pause timers and pause state.
- It fires a one-cycle strobe that sets the receive credit to zero.
- It holds both FIFO resets for a fixed number of cycles.
- It drops the reset field, which reads back as 1 for as long as the sequence runs.

Both path enables are forced off when the sequence starts. They stay off until software writes them again.

Top module: `mac_srst_seq`

## Requirements
- R1: A write with bit 3 (the reset field) set, made while no sequence is running, starts a sequence. From the next cycle, the read data shows bit 3 as 1 until the sequence ends.
- R2: Starting a sequence clears transmit enable (bit 0) and receive enable (bit 1). Both read as 0 and their output pins stay low for the whole sequence.
- R3: Both stop requests are high in every cycle of a sequence and low when no sequence is running.
- R4: The stop phase lasts until a cycle in which both idle inputs are high. That cycle is the last stop cycle. One idle input on its own does not end the phase.
- R5: If the paths never both report idle, the stop phase ends after 64 cycles.
- R6: Pause-clear and credit-clear each pulse for exactly one cycle per sequence, in the cycle right after the stop phase.
- R7: Both FIFO resets are high for exactly 4 consecutive cycles, starting right after the clear strobes. They are never high outside that window.
- R8: The reset field clears by itself in the cycle after the FIFO reset window. A sequence is therefore busy for (stop cycles + 5) cycles.
- R9: Writes made during a sequence have no effect: the enables stay 0, the sequence length does not change, and no new sequence starts.
- R10: A write with bit 3 clear, made while no sequence is running, loads bit 0 into transmit enable and bit 1 into receive enable. All other read bits are 0.
- R11: After hardware reset, the read data is 0 and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous hardware reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read data |
| rx_idle | input | 1 | Receive path is at a frame boundary or idle |
| tx_idle | input | 1 | Transmit path is at a frame boundary or idle |
| rx_stop_req | output | 1 | Asks the receive path to stop |
| tx_stop_req | output | 1 | Asks the transmit path to stop |
| tx_enable | output | 1 | Transmit path enable |
| rx_enable | output | 1 | Receive path enable |
| pause_clr | output | 1 | One-cycle strobe that clears pause timers and pause state |
| credit_clr | output | 1 | One-cycle strobe that sets the receive credit to 0 |
| rx_fifo_rst | output | 1 | Receive FIFO reset |
| tx_fifo_rst | output | 1 | Transmit FIFO reset |

## Verification
The hardest cases are at the edge of the stop timeout. In one, both paths go idle in the very last allowed stop cycle, so the graceful exit and the timeout land on the same cycle. In another, one path goes idle one cycle before the limit and the exit must still be graceful. The stimulus drives each idle input with its own delay, counted in cycles after the sequence starts. The delays are drawn at random across a range that runs past the timeout, and directed runs add the values 62 and 63 and a path that never goes idle. Writes, some with the reset field set, are dropped into random cycles of a running sequence to show they are locked out.

// File: rtl/mac_srst_pkg.sv
package mac_srst_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_STOP  = 2'd1,
    SEQ_CLEAR = 2'd2,
    SEQ_FIFO  = 2'd3
  } seq_state_t;

  // The stop phase ends in a cycle where both paths are idle, or in the
  // last cycle the timeout allows.
  function automatic logic stop_finished(input logic rx_idle, input logic tx_idle,
                                         input int waited, input int limit);
    return (rx_idle && tx_idle) || (waited + 1 >= limit);
  endfunction

  // Busy cycles of a whole sequence: the stop phase, one clear cycle and the
  // FIFO reset window.
  function automatic int busy_cycles(input int stop_cycles, input int pulse_cycles);
    return stop_cycles + 1 + pulse_cycles;
  endfunction

endpackage

// File: rtl/mac_srst_regs.sv
module mac_srst_regs #(
  parameter int DATA_W  = 8,
  parameter int RST_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              busy,
  output logic              start,
  output logic              tx_en,
  output logic              rx_en,
  output logic [DATA_W-1:0] cfg_rdata
);
  localparam int TX_BIT = 0;
  localparam int RX_BIT = 1;

  logic load_en;
  logic unused_wdata;

  assign start        = cfg_wr && cfg_wdata[RST_BIT] && !busy;
  assign load_en      = cfg_wr && !cfg_wdata[RST_BIT] && !busy;
  assign unused_wdata = ^cfg_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_en <= 1'b0;
      rx_en <= 1'b0;
    end else if (start) begin
      tx_en <= 1'b0;
      rx_en <= 1'b0;
    end else if (load_en) begin
      tx_en <= cfg_wdata[TX_BIT];
      rx_en <= cfg_wdata[RX_BIT];
    end
  end

  for (genvar b = 0; b < DATA_W; b++) begin : g_rd
    if (b == TX_BIT) begin : g_tx
      assign cfg_rdata[b] = tx_en;
    end else if (b == RX_BIT) begin : g_rx
      assign cfg_rdata[b] = rx_en;
    end else if (b == RST_BIT) begin : g_rst
      assign cfg_rdata[b] = busy;
    end else begin : g_zero
      assign cfg_rdata[b] = 1'b0;
    end
  end

  AST_ENABLES_LOW_IN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!tx_en && !rx_en)); // R2
  AST_WRITE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_wr) |=> (!tx_en && !rx_en)); // R9
  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !busy && !cfg_wdata[RST_BIT]) |=>
      (tx_en == $past(cfg_wdata[TX_BIT]) && rx_en == $past(cfg_wdata[RX_BIT]))); // R10

endmodule

// File: rtl/mac_srst_pulse.sv
module mac_srst_pulse #(
  parameter int PULSE_CYCLES = 4,
  parameter int NUM_OUTS     = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  output logic                active,
  output logic                last,
  output logic [NUM_OUTS-1:0] rst_o
);
  localparam int W = $clog2(PULSE_CYCLES + 1);

  logic [W-1:0] remain;
  logic [W-1:0] run_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (go) begin
      remain <= W'(PULSE_CYCLES);
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign active = (remain != '0);
  assign last   = (remain == W'(1));

  for (genvar g = 0; g < NUM_OUTS; g++) begin : g_out
    assign rst_o[g] = active;
  end

  // Measures each pulse so its width can be checked.
  always_ff @(posedge clk) begin
    if (!rst_n)      run_len <= '0;
    else if (active) run_len <= run_len + 1'b1;
    else             run_len <= '0;
  end

  AST_PULSE_AFTER_GO: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> active); // R7
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> (run_len == W'(PULSE_CYCLES))); // R7

endmodule

// File: rtl/mac_srst_fsm.sv
module mac_srst_fsm
  import mac_srst_pkg::*;
#(
  parameter int STOP_TIMEOUT = 64,
  parameter int PULSE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rx_idle,
  input  logic tx_idle,
  input  logic pulse_last,
  output logic busy,
  output logic stop_req,
  output logic clear_stb
);
  localparam int CNT_W = $clog2(STOP_TIMEOUT + 1);

  seq_state_t       state;
  logic [CNT_W-1:0] stop_cnt;
  logic             stop_done;
  logic [15:0]      seen_len;
  logic [15:0]      seen_stop;

  assign stop_done = stop_finished(rx_idle, tx_idle, int'(stop_cnt), STOP_TIMEOUT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SEQ_IDLE;
      stop_cnt <= '0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          stop_cnt <= '0;
          if (start) state <= SEQ_STOP;
        end
        SEQ_STOP: begin
          if (stop_done) state <= SEQ_CLEAR;
          else           stop_cnt <= stop_cnt + 1'b1;
        end
        SEQ_CLEAR: state <= SEQ_FIFO;
        SEQ_FIFO:  if (pulse_last) state <= SEQ_IDLE;
        default:   state <= SEQ_IDLE;
      endcase
    end
  end

  assign busy      = (state != SEQ_IDLE);
  assign stop_req  = busy;
  assign clear_stb = (state == SEQ_CLEAR);

  // Counts the busy cycles and stop cycles of each sequence.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_len  <= '0;
      seen_stop <= '0;
    end else if (busy) begin
      seen_len <= seen_len + 1'b1;
      if (state == SEQ_STOP) seen_stop <= seen_stop + 1'b1;
    end else begin
      seen_len  <= '0;
      seen_stop <= '0;
    end
  end

  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy); // R1
  AST_GRACEFUL_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_STOP && rx_idle && tx_idle) |=> clear_stb); // R4
  AST_TIMEOUT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_STOP) |-> (stop_cnt < CNT_W'(STOP_TIMEOUT))); // R5
  AST_STROBE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    clear_stb |=> !clear_stb); // R6
  AST_SEQ_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (int'(seen_len) == busy_cycles(int'(seen_stop), PULSE_CYCLES))); // R8

endmodule

// File: rtl/mac_srst_seq.sv
module mac_srst_seq #(
  parameter int DATA_W       = 8,
  parameter int RST_BIT      = 3,
  parameter int STOP_TIMEOUT = 64,
  parameter int PULSE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              rx_idle,
  input  logic              tx_idle,
  output logic              rx_stop_req,
  output logic              tx_stop_req,
  output logic              tx_enable,
  output logic              rx_enable,
  output logic              pause_clr,
  output logic              credit_clr,
  output logic              rx_fifo_rst,
  output logic              tx_fifo_rst
);
  localparam int NUM_FIFOS = 2;

  logic                 start;
  logic                 busy;
  logic                 stop_req;
  logic                 clear_stb;
  logic                 pulse_active;
  logic                 pulse_last;
  logic [NUM_FIFOS-1:0] fifo_rst;

  mac_srst_regs #(.DATA_W(DATA_W), .RST_BIT(RST_BIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .busy(busy), .start(start), .tx_en(tx_enable), .rx_en(rx_enable),
    .cfg_rdata(cfg_rdata)
  );

  mac_srst_fsm #(.STOP_TIMEOUT(STOP_TIMEOUT), .PULSE_CYCLES(PULSE_CYCLES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .rx_idle(rx_idle), .tx_idle(tx_idle),
    .pulse_last(pulse_last), .busy(busy), .stop_req(stop_req), .clear_stb(clear_stb)
  );

  mac_srst_pulse #(.PULSE_CYCLES(PULSE_CYCLES), .NUM_OUTS(NUM_FIFOS)) u_pulse (
    .clk(clk), .rst_n(rst_n), .go(clear_stb), .active(pulse_active),
    .last(pulse_last), .rst_o(fifo_rst)
  );

  assign rx_stop_req = stop_req;
  assign tx_stop_req = stop_req;
  assign pause_clr   = clear_stb;
  assign credit_clr  = clear_stb;
  assign rx_fifo_rst = fifo_rst[0];
  assign tx_fifo_rst = fifo_rst[1];

  AST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_rdata[RST_BIT]) |-> $past(pulse_active)); // R8
  AST_FIFO_ONLY_IN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fifo_rst || tx_fifo_rst) |-> cfg_rdata[RST_BIT]); // R7
  AST_STOP_FOLLOWS_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_stop_req && tx_stop_req) == cfg_rdata[RST_BIT]); // R3

endmodule

// File: tb/mac_srst_seq_test.sv
module mac_srst_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int TIMEOUT    = 64;
  localparam int PULSE      = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       rx_idle = 1'b0;
  logic       tx_idle = 1'b0;
  logic       rx_stop_req, tx_stop_req, tx_enable, rx_enable;
  logic       pause_clr, credit_clr, rx_fifo_rst, tx_fifo_rst;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_srst_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .rx_idle(rx_idle), .tx_idle(tx_idle),
    .rx_stop_req(rx_stop_req), .tx_stop_req(tx_stop_req),
    .tx_enable(tx_enable), .rx_enable(rx_enable), .pause_clr(pause_clr),
    .credit_clr(credit_clr), .rx_fifo_rst(rx_fifo_rst), .tx_fifo_rst(tx_fifo_rst)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Stop cycles expected from the idle delays of the two paths.
  function automatic int exp_stop_len(input int rx_d, input int tx_d);
    int m;
    m = (rx_d > tx_d) ? rx_d : tx_d;
    if (m > TIMEOUT - 1) m = TIMEOUT - 1;
    return m + 1;
  endfunction

  task automatic run_seq(input int rx_d, input int tx_d, input bit poke,
                         input int poke_at, input logic [7:0] poke_data);
    int len;
    int first_clr;
    int clr_count;
    bit busy_exp;
    len = exp_stop_len(rx_d, tx_d);
    first_clr = -1;
    clr_count = 0;
    cfg_wr = 1'b1;
    cfg_wdata = 8'($urandom) | 8'h08;
    @(negedge clk);
    for (int c = 0; c < len + PULSE + 3; c++) begin
      cfg_wr  = 1'b0;
      rx_idle = (c >= rx_d);
      tx_idle = (c >= tx_d);
      if (poke && c == poke_at) begin
        cfg_wr = 1'b1;
        cfg_wdata = poke_data;
      end
      #1;
      busy_exp = (c < len + 1 + PULSE);
      chk("R1", 32'(cfg_rdata[3]), 32'(busy_exp));
      chk("R2", {30'd0, cfg_rdata[1:0]}, 32'd0);
      chk("R9", {30'd0, rx_enable, tx_enable}, 32'd0);
      chk("R3", {30'd0, rx_stop_req, tx_stop_req}, busy_exp ? 32'd3 : 32'd0);
      chk("R6", {30'd0, credit_clr, pause_clr}, (c == len) ? 32'd3 : 32'd0);
      chk("R7", {30'd0, tx_fifo_rst, rx_fifo_rst},
          (c > len && c <= len + PULSE) ? 32'd3 : 32'd0);
      chk("R8", {24'd0, cfg_rdata}, busy_exp ? 32'h08 : 32'h00);
      if (pause_clr) begin
        clr_count++;
        if (first_clr < 0) first_clr = c;
      end
      @(negedge clk);
    end
    cfg_wr = 1'b0;
    if (len < TIMEOUT) chk("R4", 32'(first_clr), 32'(len));
    else               chk("R5", 32'(first_clr), 32'(TIMEOUT));
    chk("R6", 32'(clr_count), 32'd1);
  endtask

  task automatic idle_write(input logic [7:0] d);
    cfg_wr = 1'b1;
    cfg_wdata = d & 8'hF7;
    @(negedge clk);
    cfg_wr = 1'b0;
    #1;
    chk("R10", {24'd0, cfg_rdata}, {24'd0, 6'd0, d[1:0]});
    chk("R10", {30'd0, rx_enable, tx_enable}, {30'd0, d[1:0]});
    chk("R10", {31'd0, rx_stop_req}, 32'd0);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    chk("R11", {24'd0, cfg_rdata}, 32'd0);
    chk("R11", {24'd0, rx_stop_req, tx_stop_req, tx_enable, rx_enable,
                pause_clr, credit_clr, rx_fifo_rst, tx_fifo_rst}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corner cases.
    idle_write(8'h03);
    run_seq(0, 0, 1'b0, 0, 8'h00);
    idle_write(8'h01);
    idle_write(8'h02);
    run_seq(70, 0, 1'b0, 0, 8'h00);
    run_seq(0, 1000, 1'b0, 0, 8'h00);
    run_seq(63, 63, 1'b0, 0, 8'h00);
    run_seq(62, 5, 1'b0, 0, 8'h00);
    run_seq(10, 62, 1'b1, 3, 8'h0B);
    run_seq(5, 5, 1'b1, 8, 8'h03);
    idle_write(8'hF3);

    // Random delays, with writes dropped into running sequences.
    for (int i = 0; i < 30; i++) begin
      int rd;
      int td;
      int l;
      rd = int'($urandom_range(0, 72));
      td = int'($urandom_range(0, 72));
      l  = exp_stop_len(rd, td);
      if ($urandom_range(0, 1) == 1) idle_write(8'($urandom));
      run_seq(rd, td, ($urandom_range(0, 1) == 1),
              int'($urandom_range(0, l + PULSE)), 8'($urandom));
    end
    idle_write(8'h02);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule